// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Privilege-Aware Miss Classification

This block is a small, fully associative translation buffer for a machine with 16-bit word addresses and 256-word pages. A virtual address splits into an 8-bit page number (bits 15:8) and an 8-bit offset (bits 7:0). A hit swaps the page number for the stored frame number and leaves the offset as it is. The buffer never walks a page table. When a lookup finds nothing, it raises one of two miss flags, and a handler running in privileged mode then installs the mapping through a small command port.

The mode input selects how an address is treated. In user mode every address is looked up. In kernel mode, addresses below 0x8000 pass straight through untranslated, and only the upper half of the address space is looked up. The miss flag that rises tells the handler which of the two cases occurred.

The command port takes three operations: install an entry, search for an entry by page number, and invalidate every entry. A small controller sequences them. Its states are:
- IDLE: accepts a command. A write moves it to WRITE, a probe to PROBE and a clear to CLEAR. A code of zero keeps it in IDLE.
- WRITE, PROBE and CLEAR: each lasts one cycle, carries out the latched command, pulses done and returns to IDLE.

Top module: `soft_tlb`

## Requirements
- R1: When an address is looked up and a valid entry holds its page number, `pa` = {stored frame, `va[7:0]`} and both miss flags are low.
- R2: With `kmode`=0 and `va_valid`=1, a lookup that finds no match raises `miss_user` only, and `pa` reads 0x0000. With `va_valid`=0, both miss flags are low.
- R3: With `kmode`=1 and `va[15]`=0, `pa` equals `va` and no miss flag rises, whatever the table holds.
- R4: With `kmode`=1, `va[15]`=1 and `va_valid`=1, a lookup that finds no match raises `miss_kernel` only.
- R5: Write command (`op_sel`=2'b01): `op_arg[15:8]` is the page number and `op_arg[7:0]` is the frame number. Commands are sampled at a rising edge while idle. `op_busy` is high for the following cycle. The entry becomes valid and visible, with `op_done` high for one cycle, after the second rising edge.
- R6: A write whose page number is already present replaces that entry's frame. No second copy is made, so no other entry is lost.
- R7: A write of a new page number fills the lowest free slot. When all 8 slots are valid, it evicts exactly one entry, chosen by a free-running pseudo-random pointer.
- R8: Probe command (`op_sel`=2'b10): `probe_word` becomes {page, frame} of the matching entry, or 0x0000 when there is no match, at the same time as `op_done`. It holds that value until the next probe completes.
- R9: Clear command (`op_sel`=2'b11) invalidates all entries.
- R10: After reset all entries are invalid, and `op_busy`, `op_done` and `probe_word` are 0.
- R11: A command presented while `op_busy` is high is ignored. `op_sel`=2'b00 is ignored and does not make the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kmode | input | 1 | 1 = privileged mode |
| va_valid | input | 1 | A lookup is requested this cycle |
| va | input | 16 | Virtual address |
| pa | output | 16 | Physical address (combinational) |
| miss_user | output | 1 | Miss of a user-mode lookup |
| miss_kernel | output | 1 | Miss of a privileged lookup in the upper half |
| op_valid | input | 1 | Command strobe |
| op_sel | input | 2 | 01 write, 10 probe, 11 clear, 00 none |
| op_arg | input | 16 | Command operand {page, frame} |
| op_busy | output | 1 | Command being executed |
| op_done | output | 1 | One-cycle pulse when a command completes |
| probe_word | output | 16 | Result of the last probe |

## Verification
A wrong entry or a corrupt valid bit shows up on `pa` or on the miss flags in the same cycle as the lookup, because lookup is combinational on the stored table. A controller that sticks in a non-idle state shows up as `op_busy` held high, or as a missing `op_done` pulse, one cycle after the command. A replacement that picks the wrong slot shows up as more than one entry lost, which a count of hits across a full table detects right after the ninth write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_PROBE = 2'b10,
        OP_CLEAR = 2'b11
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_PROBE,
        ST_CLEAR
    } tlb_state_e;

    function automatic logic [7:0] lfsr_taps(input int w);
        case (w)
            2:       return 8'b0000_0011;
            3:       return 8'b0000_0110;
            4:       return 8'b0000_1100;
            5:       return 8'b0001_0100;
            6:       return 8'b0011_0000;
            7:       return 8'b0110_0000;
            8:       return 8'b1011_1000;
            default: return 8'b0000_1100;
        endcase
    endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] slot
);
    import tlb_pkg::*;
    localparam int LW = IDX_W + 1;
    localparam logic [7:0] TAPS8 = lfsr_taps(LW);
    localparam logic [LW-1:0] TAPS = TAPS8[LW-1:0];

    logic [LW-1:0] state_q;
    logic          fb;

    always_comb fb = ^(state_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= {{(LW-1){1'b0}}, 1'b1};
        else        state_q <= {state_q[LW-2:0], fb};
    end

    assign slot = state_q[IDX_W-1:0];
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             clr_en,
    input  logic [VPN_W-1:0] la_vpn,
    output logic             la_hit,
    output logic [PFN_W-1:0] la_pfn,
    input  logic [VPN_W-1:0] lb_vpn,
    output logic             lb_hit,
    output logic [IDX_W-1:0] lb_idx,
    output logic [PFN_W-1:0] lb_pfn,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx
);
    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match_a, match_b;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                vpn_q[g] <= '0;
                pfn_q[g] <= '0;
            end else if (clr_en) begin
                vld_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
                vpn_q[g] <= wr_vpn;
                pfn_q[g] <= wr_pfn;
            end
        end
        assign match_a[g] = vld_q[g] && (vpn_q[g] == la_vpn);
        assign match_b[g] = vld_q[g] && (vpn_q[g] == lb_vpn);
    end

    always_comb begin
        la_hit = |match_a;
        la_pfn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match_a[i]) la_pfn = pfn_q[i];
    end

    always_comb begin
        lb_hit = |match_b;
        lb_idx = '0;
        lb_pfn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (match_b[i]) begin
                lb_idx = IDX_W'(i);
                lb_pfn = pfn_q[i];
            end
    end

    always_comb begin
        free_any = ~&vld_q;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!vld_q[i]) free_idx = IDX_W'(i);
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ARG_W  = VPN_W + PFN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic [ARG_W-1:0] op_arg,
    input  logic             key_hit,
    input  logic [IDX_W-1:0] key_idx,
    input  logic [PFN_W-1:0] key_pfn,
    input  logic             free_any,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [IDX_W-1:0] rnd_idx,
    output logic [VPN_W-1:0] key_vpn,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [PFN_W-1:0] wr_pfn,
    output logic             clr_en,
    output logic             busy,
    output logic             done,
    output logic [ARG_W-1:0] probe_word
);
    import tlb_pkg::*;

    tlb_state_e     state_q, state_d;
    logic [ARG_W-1:0] arg_q;
    tlb_op_e        req;

    assign req = tlb_op_e'(op_sel);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (req)
                        OP_WRITE: state_d = ST_WRITE;
                        OP_PROBE: state_d = ST_PROBE;
                        OP_CLEAR: state_d = ST_CLEAR;
                        OP_NONE:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE: state_d = ST_IDLE;
            ST_PROBE: state_d = ST_IDLE;
            ST_CLEAR: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        key_vpn = arg_q[ARG_W-1:PFN_W];
        wr_pfn  = arg_q[PFN_W-1:0];
        wr_en   = 1'b0;
        clr_en  = 1'b0;
        busy    = 1'b1;
        if (key_hit)       wr_idx = key_idx;
        else if (free_any) wr_idx = free_idx;
        else               wr_idx = rnd_idx;
        unique case (state_q)
            ST_IDLE:  busy   = 1'b0;
            ST_WRITE: wr_en  = 1'b1;
            ST_PROBE: ;
            ST_CLEAR: clr_en = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q      <= '0;
            done       <= 1'b0;
            probe_word <= '0;
        end else begin
            done <= (state_q != ST_IDLE);
            if (state_q == ST_IDLE && op_valid) arg_q <= op_arg;
            if (state_q == ST_PROBE)
                probe_word <= key_hit ? {key_vpn, key_pfn} : '0;
        end
    end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 16,
    parameter int OFF_W   = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PFN_W  = VPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kmode,
    input  logic            va_valid,
    input  logic [VA_W-1:0] va,
    output logic [VA_W-1:0] pa,
    output logic            miss_user,
    output logic            miss_kernel,
    input  logic            op_valid,
    input  logic [1:0]      op_sel,
    input  logic [VA_W-1:0] op_arg,
    output logic            op_busy,
    output logic            op_done,
    output logic [VA_W-1:0] probe_word
);
    logic             wr_en, clr_en, la_hit, lb_hit, free_any;
    logic [IDX_W-1:0] wr_idx, lb_idx, free_idx, rnd_idx;
    logic [VPN_W-1:0] key_vpn;
    logic [PFN_W-1:0] wr_pfn, la_pfn, lb_pfn;
    logic             mapped;

    tlb_lfsr #(.IDX_W(IDX_W)) u_rnd (
        .clk(clk), .rst_n(rst_n), .slot(rnd_idx)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(key_vpn), .wr_pfn(wr_pfn),
        .clr_en(clr_en),
        .la_vpn(va[VA_W-1:OFF_W]), .la_hit(la_hit), .la_pfn(la_pfn),
        .lb_vpn(key_vpn), .lb_hit(lb_hit), .lb_idx(lb_idx), .lb_pfn(lb_pfn),
        .free_any(free_any), .free_idx(free_idx)
    );

    tlb_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_sel(op_sel), .op_arg(op_arg),
        .key_hit(lb_hit), .key_idx(lb_idx), .key_pfn(lb_pfn),
        .free_any(free_any), .free_idx(free_idx), .rnd_idx(rnd_idx),
        .key_vpn(key_vpn), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pfn(wr_pfn),
        .clr_en(clr_en), .busy(op_busy), .done(op_done),
        .probe_word(probe_word)
    );

    always_comb begin
        mapped      = !kmode || va[VA_W-1];
        miss_user   = 1'b0;
        miss_kernel = 1'b0;
        if (!mapped)     pa = va;
        else if (la_hit) pa = {la_pfn, va[OFF_W-1:0]};
        else begin
            pa          = '0;
            miss_user   = va_valid && !kmode;
            miss_kernel = va_valid && kmode;
        end
    end
endmodule

// File: rtl/soft_tlb_checker.sv
module soft_tlb_checker #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            kmode,
    input logic            va_valid,
    input logic [VA_W-1:0] va,
    input logic [VA_W-1:0] pa,
    input logic            miss_user,
    input logic            miss_kernel,
    input logic            op_valid,
    input logic [1:0]      op_sel,
    input logic            op_busy,
    input logic            op_done
);
    AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (kmode && !va[VA_W-1]) |-> (pa == va && !miss_user && !miss_kernel)); // R3
    AST_USER_MISS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        miss_user |-> (!kmode && va_valid && !miss_kernel)); // R2
    AST_KERN_MISS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        miss_kernel |-> (kmode && va[VA_W-1] && va_valid)); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (va_valid && !miss_user && !miss_kernel) |-> pa[OFF_W-1:0] == va[OFF_W-1:0]); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && op_valid && op_sel != 2'b00) |=> op_busy); // R5
    AST_BUSY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> (!op_busy && op_done)); // R5
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && !(op_valid && op_sel != 2'b00)) |=> !op_busy); // R11
endmodule

bind soft_tlb soft_tlb_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .kmode(kmode), .va_valid(va_valid), .va(va),
    .pa(pa), .miss_user(miss_user), .miss_kernel(miss_kernel),
    .op_valid(op_valid), .op_sel(op_sel), .op_busy(op_busy), .op_done(op_done)
);

// File: tb/sim_soft_tlb.sv
module sim_soft_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kmode = 1'b0, va_valid = 1'b0, op_valid = 1'b0;
    logic [15:0] va = '0, op_arg = '0;
    logic [1:0]  op_sel = 2'b00;
    logic [15:0] pa, probe_word;
    logic        miss_user, miss_kernel, op_busy, op_done;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    soft_tlb u0 (.*);

    // {kmode, va, expected pa, expected miss_user, expected miss_kernel}
    localparam logic [34:0] VEC [9] = '{
        {1'b0, 16'h12FF, 16'h34FF, 1'b0, 1'b0},   // R1 user hit
        {1'b0, 16'h8A00, 16'h5C00, 1'b0, 1'b0},   // R1
        {1'b0, 16'h5500, 16'h0000, 1'b1, 1'b0},   // R2 user miss
        {1'b1, 16'h1200, 16'h1200, 1'b0, 1'b0},   // R3 bypass over mapped page
        {1'b1, 16'h5501, 16'h5501, 1'b0, 1'b0},   // R3
        {1'b1, 16'h8A10, 16'h5C10, 1'b0, 1'b0},   // R1 kernel upper hit
        {1'b1, 16'hC077, 16'h0377, 1'b0, 1'b0},   // R1
        {1'b1, 16'hF000, 16'h0000, 1'b0, 1'b1},   // R4 kernel miss
        {1'b0, 16'hC001, 16'h0301, 1'b0, 1'b0}    // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xl(input logic km, input logic [15:0] a,
                      output logic [15:0] p, output logic mu, output logic mk);
        @(negedge clk);
        kmode = km; va = a; va_valid = 1'b1;
        #1;
        p = pa; mu = miss_user; mk = miss_kernel;
    endtask

    task automatic do_op(input logic [1:0] sel, input logic [15:0] arg, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_sel = sel; op_arg = arg;
        @(negedge clk);
        op_valid = 1'b0; op_sel = 2'b00;
        chk(req, {31'd0, op_busy}, 32'd1);
        @(negedge clk);
        chk(req, {31'd0, op_done}, 32'd1);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] p;
        logic mu, mk;
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        xl(1'b0, 16'h1200, p, mu, mk);
        chk("R10 miss", {31'd0, mu}, 32'd1);
        chk("R10 busy/done", {30'd0, op_busy, op_done}, 32'd0);
        chk("R10 probe", {16'd0, probe_word}, 32'd0);

        // R2 no flags without a lookup request
        @(negedge clk); va_valid = 1'b0; kmode = 1'b0; va = 16'h5500; #1;
        chk("R2 idle flags", {30'd0, miss_user, miss_kernel}, 32'd0);

        // R5 write entries
        do_op(2'b01, 16'h1234, "R5 write");
        do_op(2'b01, 16'h8A5C, "R5 write");
        do_op(2'b01, 16'hC003, "R5 write");
        for (int i = 0; i < 9; i++) begin
            xl(VEC[i][34], VEC[i][33:18], p, mu, mk);
            chk($sformatf("R1-4 vec%0d pa", i), {16'd0, p}, {16'd0, VEC[i][17:2]});
            chk($sformatf("R2/R4 vec%0d flags", i), {30'd0, mu, mk}, {30'd0, VEC[i][1:0]});
        end

        // R8 probe hit and miss
        do_op(2'b10, 16'h8A00, "R8 probe");
        chk("R8 probe hit", {16'd0, probe_word}, 32'h8A5C);
        do_op(2'b10, 16'h7700, "R8 probe");
        chk("R8 probe miss", {16'd0, probe_word}, 32'h0000);

        // R6 overwrite of an existing page
        do_op(2'b01, 16'h1299, "R6 write");
        xl(1'b0, 16'h1207, p, mu, mk);
        chk("R6 new frame", {16'd0, p}, 32'h9907);
        do_op(2'b10, 16'h1200, "R6 probe");
        chk("R6 probe", {16'd0, probe_word}, 32'h1299);

        // R11 command while busy is ignored, none code ignored
        @(negedge clk); op_valid = 1'b1; op_sel = 2'b01; op_arg = 16'h4411;
        @(negedge clk); op_arg = 16'h6622;
        @(negedge clk); op_valid = 1'b0; op_sel = 2'b00;
        @(negedge clk);
        xl(1'b0, 16'h4400, p, mu, mk);
        chk("R11 first accepted", {16'd0, p}, 32'h1100);
        xl(1'b0, 16'h6600, p, mu, mk);
        chk("R11 busy ignored", {31'd0, mu}, 32'd1);
        @(negedge clk); op_valid = 1'b1; op_sel = 2'b00; op_arg = 16'h6622;
        @(negedge clk); op_valid = 1'b0;
        chk("R11 none not busy", {31'd0, op_busy}, 32'd0);
        xl(1'b0, 16'h6600, p, mu, mk);
        chk("R11 none no write", {31'd0, mu}, 32'd1);

        // R9 clear
        do_op(2'b11, 16'h0000, "R9 clear");
        xl(1'b0, 16'h1200, p, mu, mk);
        chk("R9 cleared", {31'd0, mu}, 32'd1);
        xl(1'b1, 16'hC000, p, mu, mk);
        chk("R9 cleared kernel", {31'd0, mk}, 32'd1);

        // R7 fill all slots then one eviction
        for (int i = 0; i < 8; i++) do_op(2'b01, {8'h20 + 8'(i), 8'h40 + 8'(i)}, "R7 fill");
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            xl(1'b0, {8'h20 + 8'(i), 8'h05}, p, mu, mk);
            if (!mu && p == {8'h40 + 8'(i), 8'h05}) hits++;
        end
        chk("R7 all eight held", hits, 8);
        do_op(2'b01, 16'h3050, "R7 ninth");
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            xl(1'b0, {8'h20 + 8'(i), 8'h05}, p, mu, mk);
            if (!mu) hits++;
        end
        chk("R7 exactly one evicted", hits, 7);
        xl(1'b0, 16'h30AA, p, mu, mk);
        chk("R7 new entry", {16'd0, p}, 32'h50AA);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule